// File: doc/BRIEF.md
# Dual-width ROM read port

This block stands in for the external read side of a parallel read-only memory inside a synchronous design. A 16-bit internal array is read through a port that is either word-wide (all sixteen data lines carry the stored word) or byte-wide. In byte-wide mode the top data pin turns into an extra address bit below bit 0 that picks one half of the stored word. Two active-low controls, a chip select and an output gate, decide whether the bus is driven. A signature input replaces the array with two fixed identifier bytes.

Instead of tristate pins the block drives a data bus plus one drive flag per lane: bits 7..0, bits 14..8 and bit 15. A line whose flag is low is released, and the block then presents it as zero. Analog access times become cycle counts. An address-side counter and a shorter output-gate counter together gate a `data_valid` flag.

The port has no handshake. The system holds its inputs steady and waits for `data_valid`, as it would wait out the access time of a real part.

Top module: `dual_width_rom_port`

## Requirements
- R1: With `wide_sel` high, `ce_n` low, `oe_n` low and `sig_mode` low, all three lane flags are high and `dq_o` equals the full stored word at `addr`.
- R2: With `wide_sel` low, `byte_lsb` low puts stored bits 7..0 on `dq_o[7:0]`, and `byte_lsb` high puts stored bits 15..8 on `dq_o[7:0]`.
- R3: With `wide_sel` low, `lane_hi_en` and `lane_top_en` are low and `dq_o[15:8]` reads zero, even while the port is enabled.
- R4: `ce_n` high forces standby: all lane flags are low, `dq_o` is zero and `data_valid` is low, whatever `oe_n` is.
- R5: `ce_n` low with `oe_n` high releases every lane: all flags are low and `dq_o` is zero.
- R6: With `sig_mode` high and the port enabled, `dq_o[7:0]` is 0x20 when `addr[0]` is 0 and 0xB1 when `addr[0]` is 1, and `dq_o[15:8]` is zero.
- R7: A change of `addr`, `wide_sel`, `ce_n`, `sig_mode`, or of `byte_lsb` while byte-wide, holds `data_valid` low. With inputs then steady and the port enabled, `data_valid` first rises at the ADDR_LAT+1-th rising edge after the change.
- R8: A falling edge of `oe_n` holds `data_valid` low. It rises at the OE_LAT+1-th edge after the fall when the address-side count has already expired. OE_LAT (default 3) is below ADDR_LAT (default 5).
- R9: Driving `ce_n` or `oe_n` high clears all lane flags and `data_valid` at the first rising edge.
- R10: The stored word at address a, with i = a mod 2^ARR_AW (default 256) taken as 8 bits, is {i XOR 0xC3, NOT i}: upper byte first.
- R11: After reset, with `ce_n` high, all lane flags, `dq_o` and `data_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| wide_sel | input | 1 | 1 = word-wide, 0 = byte-wide |
| sig_mode | input | 1 | Identifier readout in place of the array |
| addr | input | ADDR_W (20) | Word address |
| byte_lsb | input | 1 | Shared pin used as the byte address below bit 0 in byte-wide mode |
| dq_o | output | 16 | Data bus, zero on released lanes |
| lane_lo_en | output | 1 | Drive flag for bits 7..0 |
| lane_hi_en | output | 1 | Drive flag for bits 14..8 |
| lane_top_en | output | 1 | Drive flag for bit 15 |
| data_valid | output | 1 | Both access counts have expired while the port is enabled |

## Verification
The bench switches `wide_sel` while the port stays enabled. A design that keeps driving the upper lanes would leave `lane_hi_en` set, and one that ignores `byte_lsb` would return the wrong half of the word. Exact edge counts after an address change and after the `oe_n` fall expose an off-by-one counter, a missed restart, or a design that lets the output-gate count stand in for the longer address count. The bench reads both identifier codes and also covers the standby case with `oe_n` low. A design that trusts `oe_n` alone would drive the bus there. Random stimulus over the whole mode table fills in the combinations in between.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'hB1;
  localparam logic [7:0] PAT_XOR  = 8'hC3;

  typedef struct packed {
    logic lo;
    logic hi;
    logic top;
  } lane_en_t;

  function automatic logic [15:0] pattern_word(input logic [7:0] idx);
    return {idx ^ PAT_XOR, ~idx};
  endfunction
endpackage

// File: rtl/rdp_array.sv
module rdp_array #(
  parameter int ADDR_W = 20,
  parameter int ARR_AW = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [15:0]       word_o
);
  import rdp_pkg::*;
  localparam int DEPTH = 1 << ARR_AW;

  logic [15:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign table_w[g] = pattern_word(8'(g));
  end

  assign word_o = table_w[addr_i[ARR_AW-1:0]];
endmodule

// File: rtl/rdp_lane_mux.sv
module rdp_lane_mux (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                wide_i,
  input  logic                lsb_i,
  input  logic                sig_i,
  input  logic                a0_i,
  input  logic [15:0]         word_i,
  output logic [15:0]         dq_o,
  output rdp_pkg::lane_en_t   lanes_o
);
  import rdp_pkg::*;

  logic [15:0] nxt;

  always_comb begin
    if (sig_i)       nxt = {8'h00, a0_i ? DEV_CODE : MFR_CODE};
    else if (wide_i) nxt = word_i;
    else             nxt = {8'h00, lsb_i ? word_i[15:8] : word_i[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_o    <= '0;
      lanes_o <= '0;
    end else begin
      lanes_o.lo  <= en_i;
      lanes_o.hi  <= en_i && wide_i;
      lanes_o.top <= en_i && wide_i;
      dq_o        <= en_i ? nxt : 16'h0000;
    end
  end

  AST_BYTE_UPPER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |=> (!lanes_o.hi && !lanes_o.top && dq_o[15:8] == 8'h00)); // R3
  AST_SIG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sig_i |=> (dq_o[15:8] == 8'h00)); // R6
endmodule

// File: rtl/rdp_access_timer.sv
module rdp_access_timer #(
  parameter int KEY_W    = 24,
  parameter int ADDR_LAT = 5,
  parameter int OE_LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_i,
  input  logic             oe_n_i,
  input  logic             en_i,
  output logic             valid_o
);
  localparam int ACW = $clog2(ADDR_LAT + 1);
  localparam int OCW = $clog2(OE_LAT + 1);

  logic [KEY_W-1:0] key_q;
  logic             oe_n_q;
  logic             en_q;
  logic [ACW-1:0]   acnt;
  logic [OCW-1:0]   ocnt;
  logic             key_chg;
  logic             oe_fall;

  assign key_chg = (key_i != key_q);
  assign oe_fall = oe_n_q && !oe_n_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= '0;
      oe_n_q <= 1'b1;
      en_q   <= 1'b0;
      acnt   <= ACW'(ADDR_LAT);
      ocnt   <= '0;
    end else begin
      key_q  <= key_i;
      oe_n_q <= oe_n_i;
      en_q   <= en_i;
      if (key_chg)          acnt <= ACW'(ADDR_LAT);
      else if (acnt != '0)  acnt <= acnt - 1'b1;
      if (oe_fall)          ocnt <= OCW'(OE_LAT);
      else if (ocnt != '0)  ocnt <= ocnt - 1'b1;
    end
  end

  assign valid_o = en_q && (acnt == '0) && (ocnt == '0);

  AST_KEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    key_chg |=> !valid_o); // R7
  AST_OE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    oe_fall |=> !valid_o); // R8
endmodule

// File: rtl/dual_width_rom_port.sv
module dual_width_rom_port #(
  parameter int ADDR_W   = 20,
  parameter int ARR_AW   = 8,
  parameter int ADDR_LAT = 5,
  parameter int OE_LAT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              wide_sel,
  input  logic              sig_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_lsb,
  output logic [15:0]       dq_o,
  output logic              lane_lo_en,
  output logic              lane_hi_en,
  output logic              lane_top_en,
  output logic              data_valid
);
  import rdp_pkg::*;
  localparam int KEY_W = ADDR_W + 4;

  logic [15:0]      word;
  logic             en;
  logic [KEY_W-1:0] key;
  lane_en_t         lanes;

  assign en  = !ce_n && !oe_n;
  assign key = {addr, wide_sel, ce_n, sig_mode, (!wide_sel && byte_lsb)};

  rdp_array #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW)) u_array (
    .addr_i (addr),
    .word_o (word)
  );

  rdp_lane_mux u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en),
    .wide_i  (wide_sel),
    .lsb_i   (byte_lsb),
    .sig_i   (sig_mode),
    .a0_i    (addr[0]),
    .word_i  (word),
    .dq_o    (dq_o),
    .lanes_o (lanes)
  );

  rdp_access_timer #(.KEY_W(KEY_W), .ADDR_LAT(ADDR_LAT), .OE_LAT(OE_LAT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_i   (key),
    .oe_n_i  (oe_n),
    .en_i    (en),
    .valid_o (data_valid)
  );

  assign lane_lo_en  = lanes.lo;
  assign lane_hi_en  = lanes.hi;
  assign lane_top_en = lanes.top;

  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!lane_lo_en && !lane_hi_en && !lane_top_en && !data_valid)); // R4
  AST_OUTPUT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |=> (!lane_lo_en && !lane_hi_en && !lane_top_en)); // R5
  AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> lane_lo_en); // R9
endmodule

// File: tb/tb_dual_width_rom_port.sv
module tb_dual_width_rom_port;
  localparam int ADDR_W   = 20;
  localparam int ARR_AW   = 8;
  localparam int ADDR_LAT = 5;
  localparam int OE_LAT   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, oe_n, wide_sel, sig_mode, byte_lsb;
  logic [ADDR_W-1:0] addr;
  logic [15:0] dq_o;
  logic lane_lo_en, lane_hi_en, lane_top_en, data_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_width_rom_port #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .ADDR_LAT(ADDR_LAT), .OE_LAT(OE_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel),
    .sig_mode(sig_mode), .addr(addr), .byte_lsb(byte_lsb), .dq_o(dq_o),
    .lane_lo_en(lane_lo_en), .lane_hi_en(lane_hi_en), .lane_top_en(lane_top_en),
    .data_valid(data_valid)
  );

  // R10 reference contents
  function automatic logic [15:0] ref_word(input logic [ADDR_W-1:0] a);
    logic [7:0] i;
    i = a[7:0];
    return {i ^ 8'hC3, ~i};
  endfunction

  function automatic logic [2:0] exp_lanes(input logic c, input logic o, input logic w);
    logic e;
    e = !c && !o;
    return {e, e && w, e && w};
  endfunction

  function automatic logic [15:0] exp_dq(input logic c, input logic o, input logic w,
                                         input logic s, input logic l, input logic [ADDR_W-1:0] a);
    logic [15:0] wd;
    wd = ref_word(a);
    if (c || o) return 16'h0000;
    if (s) return {8'h00, a[0] ? 8'hB1 : 8'h20};
    if (w) return wd;
    return {8'h00, l ? wd[15:8] : wd[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic c, input logic o, input logic w, input logic s,
                       input logic l, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    ce_n = c; oe_n = o; wide_sel = w; sig_mode = s; byte_lsb = l; addr = a;
  endtask

  task automatic check_all(input string req);
    check(req, {29'd0, lane_lo_en, lane_hi_en, lane_top_en}, {29'd0, exp_lanes(ce_n, oe_n, wide_sel)});
    check(req, {16'd0, dq_o}, {16'd0, exp_dq(ce_n, oe_n, wide_sel, sig_mode, byte_lsb, addr)});
    check(req, {31'd0, data_valid}, {31'd0, !ce_n && !oe_n});
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; wide_sel = 1'b1; sig_mode = 1'b0;
    byte_lsb = 1'b0; addr = '0;
    tick(4);
    check("R11 reset", {13'd0, lane_lo_en, lane_hi_en, lane_top_en, dq_o, data_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R4 standby with output gate active
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00012);
    tick(ADDR_LAT + 3);
    check_all("R4 standby");

    // R5 output disable
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'h00012);
    tick(ADDR_LAT + 3);
    check_all("R5 output disable");

    // R1 / R10 word read
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'hABC5A);
    tick(ADDR_LAT + 3);
    check("R1 word", {16'd0, dq_o}, {16'd0, 16'h995A ^ 16'h0000 ^ (ref_word(20'hABC5A) ^ 16'h995A)});
    check("R10 pattern", {16'd0, dq_o}, {16'd0, 16'h99A5});
    check_all("R1 word lanes");

    // R3 / R2: switch to byte-wide while enabled
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 20'hABC5A);
    tick(1);
    check("R3 upper lanes released", {30'd0, lane_hi_en, lane_top_en}, 32'd0);
    check("R2 upper half on low lane", {16'd0, dq_o}, {16'd0, 8'h00, 8'h99});
    check("R7 width change drops valid", {31'd0, data_valid}, 32'd0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20'hABC5A);
    tick(ADDR_LAT + 3);
    check("R2 lower half", {16'd0, dq_o}, {16'd0, 8'h00, 8'hA5});
    check_all("R2 byte lanes");

    // R6 identifier codes
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00200);
    tick(ADDR_LAT + 3);
    check("R6 manufacturer code", {16'd0, dq_o}, 32'h0000_0020);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00201);
    tick(ADDR_LAT + 3);
    check("R6 device code", {16'd0, dq_o}, 32'h0000_00B1);

    // R7 exact address latency
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00033);
    tick(ADDR_LAT + 4);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00034);
    for (int k = 1; k <= ADDR_LAT + 1; k++) begin
      tick(1);
      check("R7 address latency", {31'd0, data_valid}, {31'd0, k == ADDR_LAT + 1});
    end
    check("R1 word after latency", {16'd0, dq_o}, {16'd0, ref_word(20'h00034)});

    // R7 byte address pin counts as address in byte mode
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00034);
    tick(ADDR_LAT + 4);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00034);
    tick(1);
    check("R7 byte pin restart", {31'd0, data_valid}, 32'd0);

    // R9 disable through output gate
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'h00034);
    tick(1);
    check("R9 oe disable", {28'd0, lane_lo_en, lane_hi_en, lane_top_en, data_valid}, 32'd0);
    tick(ADDR_LAT + 3);

    // R8 exact output-gate latency
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00034);
    for (int k = 1; k <= OE_LAT + 1; k++) begin
      tick(1);
      check("R8 output gate latency", {31'd0, data_valid}, {31'd0, k == OE_LAT + 1});
    end

    // R9 disable through chip select
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00034);
    tick(1);
    check("R9 ce disable", {28'd0, lane_lo_en, lane_hi_en, lane_top_en, data_valid}, 32'd0);

    // random mix over the mode table (R1..R6, R10)
    for (int it = 0; it < 300; it++) begin
      logic c, o, w, s, l;
      logic [ADDR_W-1:0] a;
      c = ($urandom % 5) == 0;
      o = ($urandom % 5) == 0;
      w = $urandom % 2;
      s = ($urandom % 6) == 0;
      l = $urandom % 2;
      a = ADDR_W'($urandom);
      drive(c, o, w, s, l, a);
      tick(ADDR_LAT + 3);
      check_all("R1-mode random R2 R3 R4 R5 R6 R10");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule